// File: doc/BRIEF.md
# Pipelined No-Turnaround Synchronous SRAM

This block is a synchronous, pipelined, common-I/O memory. Each clock it can accept a new command: a read, a write or a deselect. No idle cycles are needed when reads and writes are mixed. Write data is taken two rising edges after its command, and read data leaves through an output register one edge after its command. Because of this offset, the read and write data phases of neighbouring commands never overlap on the bus. The memory core is behavioural. The data word is 72 bits, split into eight lanes of nine bits, and each lane has its own write select.

A command is loaded when the load/advance input is low. Each following cycle with load/advance high runs the next beat of a four-beat burst, in either linear or exclusive-or order. The real bidirectional pin is modelled as a separate input bus, a separate output bus and a drive-enable output. This lets the surrounding logic and the testbench check that the bus is released in the right cycles. An active-low clock enable freezes the whole block.

Top module: `nt_sram`

## Requirements
- R1: A command is accepted at a rising edge where `clk_en_n` is low and `advance` is low. If `sel0_n`=0, `sel1`=1 and `sel2_n`=0 all hold, it is a write when `wr_n` is low and a read when `wr_n` is high. Otherwise it is a deselect that changes no memory contents.
- R2: For a read accepted at edge N, `rdata` carries the stored word after edge N+1, with `drive_en` high, and not before.
- R3: `drive_en` is high only while `out_en_n` is low, and it follows `out_en_n` without waiting for a clock.
- R4: For a write accepted at edge N, `drive_en` is low between edges N+1 and N+2, whatever the level of `out_en_n`. The word on `wdata` is stored at edge N+2.
- R5: Lane i occupies bits [9i+8:9i]. It is written only when `lane_wr_n[i]` is low in the command or beat cycle. Unselected lanes keep their contents.
- R6: A cycle with `advance` high continues the last loaded burst at the next beat, with the same direction, and ignores `sel0_n`, `sel1`, `sel2_n` and `wr_n`. The two low address bits of beat n are base+n modulo 4 when `order_xor` was low at the load, and base XOR n when it was high. The upper bits do not change. The fifth beat wraps to the base address.
- R7: A deselect passes through the pipeline, so `drive_en` is low after the edge following the deselect edge. Advance cycles that follow a deselect are also deselects.
- R8: While `clk_en_n` is high, all state holds. This includes pipeline stages, burst position, output register and any pending write. Commands presented during the stall are dropped.
- R9: A read accepted on the edge right after a write to the same address returns the new write data merged with the old contents of the lanes that were not selected.
- R10: Reads and writes may alternate on consecutive edges without idle cycles, and each returns or stores the correct data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en_n | input | 1 | Clock enable, active low; high stalls everything |
| sel0_n | input | 1 | Chip select, active low |
| sel1 | input | 1 | Chip select, active high |
| sel2_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Low = write, high = read, sampled at load |
| advance | input | 1 | Low = load a new command, high = next burst beat |
| order_xor | input | 1 | Burst order at load: 0 linear, 1 exclusive-or |
| addr | input | ADDR_W | Word address |
| lane_wr_n | input | LANES | Per-lane write select, active low |
| out_en_n | input | 1 | Output enable, active low, asynchronous |
| wdata | input | LANES*LANE_W | Write data bus |
| rdata | output | LANES*LANE_W | Registered read data |
| drive_en | output | 1 | High when the block drives the shared bus |

## Verification
A wrong pipeline stage shows up on `drive_en` within two edges of the command. The bus is then driven during a write data phase, or it stays driven after a deselect. A wrong burst position or captured order shows up as a wrong word on `rdata` at the first mis-sequenced beat. A missed forward from a pending write shows up only on a read that immediately follows a write to the same address, one edge after the read. A stall that leaks shows up as `rdata` changing while `clk_en_n` is high, or as a later read returning a word that a dropped command overwrote.

// File: rtl/nt_sram_pkg.sv
package nt_sram_pkg;
    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_RD   = 2'd1,
        OP_WR   = 2'd2
    } op_e;
endpackage

// File: rtl/nt_burst_seq.sv
// Beat address generator: linear (add) or exclusive-or order on the low bits.
module nt_burst_seq #(
    parameter int ADDR_W  = 6,
    parameter int BURST_W = 2
) (
    input  logic [ADDR_W-1:0]  base,
    input  logic [BURST_W-1:0] step,
    input  logic               use_xor,
    output logic [ADDR_W-1:0]  beat_addr
);
    logic [BURST_W-1:0] lo_base;
    logic [BURST_W-1:0] lo_beat;

    assign lo_base = base[BURST_W-1:0];
    assign lo_beat = use_xor ? (lo_base ^ step) : (lo_base + step);

    generate
        if (ADDR_W > BURST_W) begin : g_hi
            assign beat_addr = {base[ADDR_W-1:BURST_W], lo_beat};
        end else begin : g_lo
            assign beat_addr = lo_beat;
        end
    endgenerate
endmodule

// File: rtl/nt_lane_merge.sv
// Lane-wise select between an older word and a newer word.
module nt_lane_merge #(
    parameter int LANES  = 8,
    parameter int LANE_W = 9
) (
    input  logic [LANES*LANE_W-1:0] old_word,
    input  logic [LANES*LANE_W-1:0] new_word,
    input  logic [LANES-1:0]        take_new,
    output logic [LANES*LANE_W-1:0] merged
);
    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            assign merged[g*LANE_W +: LANE_W] =
                take_new[g] ? new_word[g*LANE_W +: LANE_W] : old_word[g*LANE_W +: LANE_W];
        end
    endgenerate
endmodule

// File: rtl/nt_sram_array.sv
// Behavioural storage: one array per lane, asynchronous read, lane-masked write.
module nt_sram_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 8,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    wr_go,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LANES-1:0]        wr_lanes,
    input  logic [LANES*LANE_W-1:0] wr_word,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [LANES*LANE_W-1:0] rd_word
);
    localparam int DEPTH = 1 << ADDR_W;

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            logic [LANE_W-1:0] cells [DEPTH];

            always_ff @(posedge clk) begin
                if (wr_go && wr_lanes[g]) begin
                    cells[wr_addr] <= wr_word[g*LANE_W +: LANE_W];
                end
            end

            assign rd_word[g*LANE_W +: LANE_W] = cells[rd_addr];
        end
    endgenerate
endmodule

// File: rtl/nt_sram.sv
// Pipelined common-I/O SRAM with late write data and no bus turnaround cycles.
module nt_sram
    import nt_sram_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int LANES   = 8,
    parameter int LANE_W  = 9,
    parameter int BURST_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clk_en_n,
    input  logic                    sel0_n,
    input  logic                    sel1,
    input  logic                    sel2_n,
    input  logic                    wr_n,
    input  logic                    advance,
    input  logic                    order_xor,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES-1:0]        lane_wr_n,
    input  logic                    out_en_n,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    drive_en
);
    localparam int DATA_W = LANES * LANE_W;

    typedef struct packed {
        op_e                s1_op;     // command stage
        logic [ADDR_W-1:0]  s1_addr;
        logic [LANES-1:0]   s1_lanes;
        op_e                s2_op;     // data stage
        logic [ADDR_W-1:0]  s2_addr;
        logic [LANES-1:0]   s2_lanes;
        logic               b_live;    // burst context
        logic               b_write;
        logic               b_xor;
        logic [ADDR_W-1:0]  b_base;
        logic [BURST_W-1:0] b_step;
        logic [DATA_W-1:0]  dout;      // output register
    } state_t;

    state_t st_q, st_d;

    logic               sel_all;
    logic [BURST_W-1:0] step_next;
    logic [ADDR_W-1:0]  beat_addr;
    logic [DATA_W-1:0]  core_word;
    logic [DATA_W-1:0]  fwd_word;
    logic [LANES-1:0]   fwd_lanes;
    logic               commit;

    assign sel_all   = !sel0_n && sel1 && !sel2_n;
    assign step_next = st_q.b_step + BURST_W'(1);

    nt_burst_seq #(
        .ADDR_W (ADDR_W),
        .BURST_W(BURST_W)
    ) u_seq (
        .base     (st_q.b_base),
        .step     (step_next),
        .use_xor  (st_q.b_xor),
        .beat_addr(beat_addr)
    );

    // Write commits at the edge that ends its data phase.
    assign commit = !clk_en_n && (st_q.s2_op == OP_WR);

    nt_sram_array #(
        .ADDR_W(ADDR_W),
        .LANES (LANES),
        .LANE_W(LANE_W)
    ) u_array (
        .clk     (clk),
        .wr_go   (commit),
        .wr_addr (st_q.s2_addr),
        .wr_lanes(st_q.s2_lanes),
        .wr_word (wdata),
        .rd_addr (st_q.s1_addr),
        .rd_word (core_word)
    );

    // Read in stage 1 meets a write committing at the same edge.
    assign fwd_lanes = ((st_q.s2_op == OP_WR) && (st_q.s2_addr == st_q.s1_addr))
                       ? st_q.s2_lanes : '0;

    nt_lane_merge #(
        .LANES (LANES),
        .LANE_W(LANE_W)
    ) u_fwd (
        .old_word(core_word),
        .new_word(wdata),
        .take_new(fwd_lanes),
        .merged  (fwd_word)
    );

    always_comb begin
        st_d = st_q;
        if (!clk_en_n) begin
            st_d.s2_op    = st_q.s1_op;
            st_d.s2_addr  = st_q.s1_addr;
            st_d.s2_lanes = st_q.s1_lanes;
            if (st_q.s1_op == OP_RD) begin
                st_d.dout = fwd_word;
            end
            if (!advance) begin
                st_d.s1_addr  = addr;
                st_d.s1_lanes = ~lane_wr_n;
                st_d.b_step   = '0;
                st_d.b_base   = addr;
                st_d.b_xor    = order_xor;
                st_d.b_write  = !wr_n;
                st_d.b_live   = sel_all;
                if (sel_all) begin
                    st_d.s1_op = wr_n ? OP_RD : OP_WR;
                end else begin
                    st_d.s1_op = OP_NONE;
                end
            end else begin
                st_d.b_step   = step_next;
                st_d.s1_addr  = beat_addr;
                st_d.s1_lanes = ~lane_wr_n;
                if (st_q.b_live) begin
                    st_d.s1_op = st_q.b_write ? OP_WR : OP_RD;
                end else begin
                    st_d.s1_op = OP_NONE;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata    = st_q.dout;
    assign drive_en = (st_q.s2_op == OP_RD) && !out_en_n;
endmodule

// File: rtl/nt_sram_chk.sv
// Port-level timing properties, bound to nt_sram.
module nt_sram_chk #(
    parameter int DATA_W = 72
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clk_en_n,
    input logic              sel0_n,
    input logic              sel1,
    input logic              sel2_n,
    input logic              wr_n,
    input logic              advance,
    input logic              out_en_n,
    input logic [DATA_W-1:0] rdata,
    input logic              drive_en
);
    logic sel_all;
    logic take_wr;
    logic take_rd;
    logic take_off;

    assign sel_all  = !sel0_n && sel1 && !sel2_n;
    assign take_wr  = !clk_en_n && !advance && sel_all && !wr_n;
    assign take_rd  = !clk_en_n && !advance && sel_all && wr_n;
    assign take_off = !clk_en_n && !advance && !sel_all;

    // R2: read drives after the next active edge (subject to output enable)
    p_read_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take_rd ##1 !clk_en_n |=> (drive_en == !out_en_n));

    // R3: output enable high keeps the bus released
    p_oe_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_n |-> !drive_en);

    // R4: bus released during the write data phase
    p_write_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        take_wr ##1 !clk_en_n |=> !drive_en);

    // R7: deselect releases the bus one edge later
    p_deselect_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        take_off ##1 !clk_en_n |=> !drive_en);

    // R8: a stalled edge leaves the output register alone
    p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_n |=> $stable(rdata));
endmodule

bind nt_sram nt_sram_chk #(.DATA_W(LANES*LANE_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .clk_en_n(clk_en_n),
    .sel0_n  (sel0_n),
    .sel1    (sel1),
    .sel2_n  (sel2_n),
    .wr_n    (wr_n),
    .advance (advance),
    .out_en_n(out_en_n),
    .rdata   (rdata),
    .drive_en(drive_en)
);

// File: tb/nt_sram_bench.sv
module nt_sram_bench;
    localparam int AW = 6;
    localparam int NL = 8;
    localparam int LW = 9;
    localparam int DW = NL * LW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clk_en_n = 1'b0;
    logic          sel0_n = 1'b1;
    logic          sel1 = 1'b0;
    logic          sel2_n = 1'b1;
    logic          wr_n = 1'b1;
    logic          advance = 1'b0;
    logic          order_xor = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [NL-1:0] lane_wr_n = '1;
    logic          out_en_n = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          drive_en;

    int errors = 0;
    int checks = 0;
    logic [DW-1:0] mdl [1<<AW];

    always #2 clk = ~clk;  // 250 MHz

    nt_sram u_nt_sram (
        .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n),
        .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
        .wr_n(wr_n), .advance(advance), .order_xor(order_xor),
        .addr(addr), .lane_wr_n(lane_wr_n), .out_en_n(out_en_n),
        .wdata(wdata), .rdata(rdata), .drive_en(drive_en)
    );

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat(input int k);
        logic [DW-1:0] w;
        for (int l = 0; l < NL; l++) w[l*LW +: LW] = LW'((k * 37 + l * 11 + 5) % 512);
        return w;
    endfunction

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] o, input logic [DW-1:0] n,
                                            input logic [NL-1:0] be_n);
        logic [DW-1:0] w;
        for (int l = 0; l < NL; l++) w[l*LW +: LW] = be_n[l] ? o[l*LW +: LW] : n[l*LW +: LW];
        return w;
    endfunction

    function automatic logic [AW-1:0] beat(input logic [AW-1:0] base, input int n, input logic x);
        logic [1:0] lo;
        lo = x ? (base[1:0] ^ 2'(n)) : (base[1:0] + 2'(n));
        return {base[AW-1:2], lo};
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic set_load(input logic is_wr, input logic [AW-1:0] a, input logic [NL-1:0] be_n);
        clk_en_n = 0; advance = 0; sel0_n = 0; sel1 = 1; sel2_n = 0;
        wr_n = !is_wr; addr = a; lane_wr_n = be_n;
    endtask

    // chip selects and write enable deliberately set to values that must be ignored
    task automatic set_adv(input logic [NL-1:0] be_n);
        clk_en_n = 0; advance = 1; sel0_n = 1; sel1 = 0; sel2_n = 1;
        wr_n = ~wr_n; addr = ~addr; lane_wr_n = be_n;
    endtask

    task automatic set_off();
        clk_en_n = 0; advance = 0; sel0_n = 1; sel1 = 1; sel2_n = 0;
        wr_n = 1; lane_wr_n = '1;
    endtask

    task automatic single_write(input logic [AW-1:0] a, input logic [NL-1:0] be_n,
                                input logic [DW-1:0] d);
        set_load(1, a, be_n); tick();
        set_off(); out_en_n = 0; tick();
        chk("R4 bus released in write data phase", DW'(drive_en), DW'(0));
        wdata = d; set_off(); tick();
        mdl[a] = merge(mdl[a], d, be_n);
    endtask

    task automatic single_read(input logic [AW-1:0] a, input string req);
        set_load(0, a, '1); tick();
        chk({req, " not driven before latency"}, DW'(drive_en), DW'(0));
        set_off(); tick();
        chk({req, " read data"}, rdata, mdl[a]);
        chk({req, " read drive"}, DW'(drive_en), DW'(1));
    endtask

    task automatic t_reset();
        chk("R7 reset leaves bus released", DW'(drive_en), DW'(0));
    endtask

    task automatic t_single();
        for (int a = 0; a < 24; a++) single_write(AW'(a), '0, pat(100 + a));
        single_read(6'd5, "R1 R2");
        out_en_n = 1; #1;
        chk("R3 output enable high releases bus", DW'(drive_en), DW'(0));
        out_en_n = 0; #1;
        chk("R3 output enable low drives again", DW'(drive_en), DW'(1));
    endtask

    task automatic t_lanes();
        single_write(6'd5, 8'b1010_1010, pat(7));
        single_read(6'd5, "R5 lane mask");
        single_write(6'd6, 8'b0111_1110, pat(8));
        single_read(6'd6, "R5 edge lanes");
    endtask

    task automatic t_mix();
        logic [DW-1:0] exp8;
        set_load(1, 6'd8, 8'h0F); tick();           // E0 write 8, upper lanes
        set_load(0, 6'd8, '1); out_en_n = 0; tick(); // E1 read 8
        chk("R4 write data phase released", DW'(drive_en), DW'(0));
        wdata = pat(50);
        exp8 = merge(mdl[8], pat(50), 8'h0F);
        mdl[8] = exp8;
        set_load(1, 6'd9, '0); tick();              // E2 write 9, commit 8
        chk("R9 forwarded merged read", rdata, exp8);
        chk("R10 read driven right after write", DW'(drive_en), DW'(1));
        set_load(0, 6'd9, '1); tick();              // E3 read 9
        chk("R10 write phase after read released", DW'(drive_en), DW'(0));
        wdata = pat(51); mdl[9] = pat(51);
        set_off(); tick();                          // E4 commit 9
        chk("R10 R9 full-word forward", rdata, pat(51));
        set_off(); tick();
        single_read(6'd8, "R9 stored after forward");
    endtask

    task automatic rd_burst(input logic [AW-1:0] base, input logic x, input int beats,
                            input string req);
        for (int c = 0; c <= beats; c++) begin
            if (c == 0) begin
                set_load(0, base, '1); order_xor = x;
            end else if (c < beats) begin
                set_adv('1); order_xor = !x;   // order must stay as captured
            end else begin
                set_off();
            end
            tick();
            if (c >= 1) begin
                chk(req, rdata, mdl[beat(base, c - 1, x)]);
                chk({req, " drive"}, DW'(drive_en), DW'(1));
            end
        end
        set_off(); tick();
    endtask

    task automatic t_burst();
        for (int c = 0; c <= 5; c++) begin
            if (c == 0) begin
                set_load(1, 6'h12, '0); order_xor = 0;
            end else if (c <= 3) begin
                set_adv('0);
            end else begin
                set_off();
            end
            if (c >= 2) wdata = pat(10 + c - 2);
            tick();
            if (c >= 1 && c <= 4)
                chk("R4 R6 burst write phase released", DW'(drive_en), DW'(0));
        end
        for (int i = 0; i < 4; i++) mdl[beat(6'h12, i, 0)] = pat(10 + i);
        rd_burst(6'h12, 0, 4, "R6 linear burst read");
        rd_burst(6'h11, 1, 5, "R6 xor burst read with wrap");
        rd_burst(6'h13, 0, 5, "R6 linear burst wrap");
    endtask

    task automatic t_stall();
        logic [DW-1:0] held;
        set_load(0, 6'h10, '1); order_xor = 0; tick();
        set_adv('1); tick();
        chk("R8 first beat before stall", rdata, mdl[6'h10]);
        held = rdata;
        for (int s = 0; s < 3; s++) begin
            clk_en_n = 1; advance = 0; sel0_n = 0; sel1 = 1; sel2_n = 0;
            wr_n = 0; addr = 6'd5; lane_wr_n = '0; wdata = pat(900 + s);
            tick();
            chk("R8 output held while stalled", rdata, held);
            chk("R8 drive held while stalled", DW'(drive_en), DW'(1));
        end
        set_adv('1); tick();
        chk("R8 burst position kept across stall", rdata, mdl[6'h11]);
        set_off(); tick();
        set_off(); tick();
        single_read(6'd5, "R8 stalled command dropped");
    endtask

    task automatic t_deselect();
        set_load(0, 6'h11, '1); tick();
        set_load(1, 6'd5, '0); sel0_n = 1; tick();   // deselect carrying write level
        chk("R7 read before deselect still out", rdata, mdl[6'h11]);
        set_adv('0); sel0_n = 0; sel1 = 1; sel2_n = 0; wr_n = 0; wdata = pat(777); tick();
        chk("R7 deselect releases bus", DW'(drive_en), DW'(0));
        set_adv('0); wdata = pat(778); tick();
        chk("R7 advance after deselect stays released", DW'(drive_en), DW'(0));
        set_off(); tick();
        chk("R7 still released", DW'(drive_en), DW'(0));
        set_off(); tick();
        single_read(6'd5, "R1 R7 deselect wrote nothing");
        single_read(6'd7, "R1 R7 neighbour untouched");
    endtask

    initial begin
        for (int i = 0; i < (1 << AW); i++) mdl[i] = '0;
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1;
        set_off(); tick();
        t_single();
        t_lanes();
        t_mix();
        t_burst();
        t_stall();
        t_deselect();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule